// File: doc/BRIEF.md
# Dual-Mode Inverter Gate Sequencer

This block produces the twelve gate commands of a three-phase drive in which a six-transistor bridge feeds the motor through one antiparallel thyristor pair per phase. It works from a 12-bit rotor electrical angle, where 4096 counts make one electrical cycle. It steps through the six phase-pair states of a trapezoidal-emf machine. Two drive styles are available. In low-speed mode, the transistors of the active phase pair are chopped by three hysteresis-band comparator results. In high-speed mode, the transistors follow a fundamental-frequency pattern. That pattern is moved earlier by an advance angle, and each transistor stays on for half a cycle less a blanking angle.

In both modes the thyristors are fired once per half cycle per direction. They turn off by themselves at current zero, so the block has no turn-off output for them. The advance and blanking setpoints are sampled only when a new 60-degree state begins. A fault input latches and silences every gate, so the motor current decays within half a cycle. Each bridge leg has a programmable dead time that keeps its two transistors apart.

Top module: `dmi_gate_seq`

## Requirements
- R1: The status output `state_idx` equals floor(6·θ/4096), where θ = (angle + latched advance) mod 4096. Values 0..5 stand for the pairs A+B−, A+C−, B+C−, B+A−, C+A−, C+B−.
- R2: The phase position is p = θ for phase A, p = (θ − 1365) mod 4096 for phase B and p = (θ − 2731) mod 4096 for phase C. Bit 0, 1 and 2 of every three-bit gate or comparator bus belong to A, B and C.
- R3: In high-speed mode (`mode_hi` = 1), the upper transistor of a phase is requested for 0 ≤ p < 2048 − blank. The lower one is requested for 2048 ≤ p < 4096 − blank. Comparators are ignored.
- R4: In low-speed mode (`mode_hi` = 0), the windows are those of R3 with blank forced to 682 counts. The upper or lower request is also ANDed with that phase's comparator bit (1 = current below band, switch on). The blanking input has no effect.
- R5: In both modes, the forward thyristor of a phase is fired for p < 2048 and the reverse thyristor for p ≥ 2048.
- R6: Advance and blanking inputs above 682 counts (60 degrees) are treated as 682.
- R7: Advance and blanking are latched in the first cycle after reset and whenever the state index changes. A setpoint change inside a state has no effect on the gates until the next state begins.
- R8: The upper and lower transistor gates of one leg are never high together. After one of them falls, the other stays low for at least `DEAD_CYC` cycles.
- R9: A `fault` pulse is latched. From the second rising edge after the pulse onward, all twelve gate outputs stay low until reset, whatever the other inputs do.
- R10: While `rst` is high, all gate outputs are low and `state_idx` is 0.
- R11: `hs_mode` shows the value `mode_hi` had one clock earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| angle | input | 12 | Rotor electrical angle, 4096 counts per cycle |
| adv_ang | input | 12 | Advance angle setpoint |
| blank_ang | input | 12 | Blanking angle setpoint |
| mode_hi | input | 1 | 1 = high-speed phase advance, 0 = low-speed current regulation |
| cmp | input | 3 | Hysteresis comparator results per phase |
| fault | input | 1 | Fault request, latched |
| q_up | output | 3 | Upper transistor gates per phase |
| q_dn | output | 3 | Lower transistor gates per phase |
| t_fwd | output | 3 | Forward thyristor gates per phase |
| t_rev | output | 3 | Reverse thyristor gates per phase |
| state_idx | output | 3 | Current phase-pair state 0..5 |
| hs_mode | output | 1 | Registered mode flag |

## Verification
The bench keeps the default 12-bit angle and a dead time of two cycles. With these values every one of the 4096 angle codes can be visited, in four settings: plain 120-degree drive, a mid-range advance with partial blanking, clamped advance with zero blanking, and comparator-chopped low-speed drive. At each code, all twelve gates and the state index are compared with values computed arithmetically in the bench. The short dead time lets the full gap between the two switches of a leg be measured cycle by cycle at a direct hand-over.

// File: rtl/dmi_pkg.sv
package dmi_pkg;

    // Drive style selected by the mode input
    typedef enum logic {
        MODE_LOW  = 1'b0,
        MODE_HIGH = 1'b1
    } drv_mode_t;

    // Transistor request for one bridge leg
    typedef struct packed {
        logic up;
        logic dn;
    } leg_req_t;

    // Phase offset of leg k in angle counts, for a cycle of full_cnt counts
    function automatic int leg_offset(input int k, input int full_cnt);
        int third;
        third = full_cnt / 3;
        if (k == 0)
            return 0;
        else if (k == 1)
            return third;
        else
            return full_cnt - third;
    endfunction

endpackage

// File: rtl/dmi_setpoint.sv
module dmi_setpoint
    import dmi_pkg::*;
#(
    parameter int ANG_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ANG_W-1:0] angle,
    input  logic [ANG_W-1:0] adv_in,
    input  logic [ANG_W-1:0] blk_in,
    output logic [ANG_W-1:0] theta,
    output logic [ANG_W-1:0] blk_q,
    output logic [2:0]       state_q
);
    localparam int FULL  = 1 << ANG_W;
    localparam int SIXTH = FULL / 6;
    localparam logic [ANG_W-1:0] LIM = ANG_W'(SIXTH);

    logic [ANG_W-1:0] adv_q;
    logic             pend_q;
    logic [ANG_W+2:0] prod;
    logic [2:0]       sector_now;
    logic [ANG_W-1:0] adv_c, blk_c;

    assign theta      = angle + adv_q;
    assign prod       = ({3'b000, theta} << 2) + ({3'b000, theta} << 1);
    assign sector_now = prod[ANG_W+2:ANG_W];
    assign adv_c      = (adv_in > LIM) ? LIM : adv_in;
    assign blk_c      = (blk_in > LIM) ? LIM : blk_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            adv_q   <= '0;
            blk_q   <= LIM;
            state_q <= 3'd0;
            pend_q  <= 1'b1;
        end else if (pend_q || (sector_now != state_q)) begin
            adv_q   <= adv_c;
            blk_q   <= blk_c;
            state_q <= sector_now;
            pend_q  <= 1'b0;
        end
    end

    // R6: latched setpoints never exceed 60 degrees
    assert_sp_clamp_R6: assert property (@(posedge clk) disable iff (rst)
        (adv_q <= LIM) && (blk_q <= LIM));

    // R7: setpoints only move when a new state begins
    assert_sp_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ($stable(state_q) && !$past(pend_q)) |-> ($stable(adv_q) && $stable(blk_q)));

    // R1: state index stays within the six phase-pair states
    assert_state_range_R1: assert property (@(posedge clk) disable iff (rst)
        state_q < 3'd6);

endmodule

// File: rtl/dmi_phase_win.sv
module dmi_phase_win
    import dmi_pkg::*;
#(
    parameter int ANG_W  = 12,
    parameter int OFFSET = 0
) (
    input  logic [ANG_W-1:0] theta,
    input  logic [ANG_W-1:0] blk,
    input  drv_mode_t        mode,
    input  logic             cmp,
    output leg_req_t         req,
    output logic             thy_fwd,
    output logic             thy_rev
);
    localparam int FULL  = 1 << ANG_W;
    localparam int HALF  = FULL / 2;
    localparam int SIXTH = FULL / 6;

    logic [ANG_W-1:0] pos;
    logic [ANG_W:0]   pos_x, blk_eff, up_lim, dn_lim;
    logic             up_win, dn_win, chop_ok;

    assign pos     = theta - ANG_W'(OFFSET);
    assign pos_x   = {1'b0, pos};
    assign blk_eff = (mode == MODE_HIGH) ? {1'b0, blk} : (ANG_W+1)'(SIXTH);
    assign up_lim  = (ANG_W+1)'(HALF) - blk_eff;
    assign dn_lim  = (ANG_W+1)'(FULL) - blk_eff;
    assign up_win  = pos_x < up_lim;
    assign dn_win  = (pos_x >= (ANG_W+1)'(HALF)) && (pos_x < dn_lim);
    assign chop_ok = (mode == MODE_HIGH) || cmp;

    always_comb begin
        req.up = up_win && chop_ok;
        req.dn = dn_win && chop_ok;
    end

    assign thy_fwd = ~pos[ANG_W-1];
    assign thy_rev =  pos[ANG_W-1];

endmodule

// File: rtl/dmi_leg_dt.sv
module dmi_leg_dt
    import dmi_pkg::*;
#(
    parameter int DEAD_CYC = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     kill,
    input  leg_req_t req,
    output logic     up_q,
    output logic     dn_q
);
    localparam int CNT_W = $clog2(DEAD_CYC + 1);
    localparam logic [CNT_W-1:0] DEAD = CNT_W'(DEAD_CYC);

    logic [CNT_W-1:0] cnt_q;
    logic             gap_ok;

    assign gap_ok = (cnt_q == DEAD);

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            up_q  <= 1'b0;
            dn_q  <= 1'b0;
            cnt_q <= '0;
        end else begin
            up_q <= req.up && !req.dn && (up_q || (!dn_q && gap_ok));
            dn_q <= req.dn && !req.up && (dn_q || (!up_q && gap_ok));
            if (up_q || dn_q)
                cnt_q <= '0;
            else if (!gap_ok)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // Checker-side count of consecutive cycles with both gates low
    logic [CNT_W-1:0] off_run;
    always_ff @(posedge clk) begin
        if (rst)
            off_run <= '0;
        else if (up_q || dn_q)
            off_run <= '0;
        else if (off_run != DEAD)
            off_run <= off_run + 1'b1;
    end

    // R8: the two switches of a leg are never on together
    assert_leg_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(up_q && dn_q));

    // R8: a switch only turns on after a full dead-time gap
    assert_up_gap_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(up_q) |-> ($past(off_run) == DEAD));
    assert_dn_gap_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(dn_q) |-> ($past(off_run) == DEAD));

    // R9: a kill request silences the leg on the next edge
    assert_leg_kill_R9: assert property (@(posedge clk) disable iff (rst)
        kill |=> (!up_q && !dn_q));

endmodule

// File: rtl/dmi_gate_seq.sv
module dmi_gate_seq
    import dmi_pkg::*;
#(
    parameter int ANG_W    = 12,
    parameter int DEAD_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ANG_W-1:0] angle,
    input  logic [ANG_W-1:0] adv_ang,
    input  logic [ANG_W-1:0] blank_ang,
    input  logic             mode_hi,
    input  logic [2:0]       cmp,
    input  logic             fault,
    output logic [2:0]       q_up,
    output logic [2:0]       q_dn,
    output logic [2:0]       t_fwd,
    output logic [2:0]       t_rev,
    output logic [2:0]       state_idx,
    output logic             hs_mode
);
    localparam int FULL   = 1 << ANG_W;
    localparam int N_LEGS = 3;

    logic [ANG_W-1:0] theta, blk_q;
    logic             fault_q;
    drv_mode_t        mode_q;
    leg_req_t         req [N_LEGS];
    logic [2:0]       fwd_c, rev_c;

    dmi_setpoint #(.ANG_W(ANG_W)) u_sp (
        .clk     (clk),
        .rst     (rst),
        .angle   (angle),
        .adv_in  (adv_ang),
        .blk_in  (blank_ang),
        .theta   (theta),
        .blk_q   (blk_q),
        .state_q (state_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
            mode_q  <= MODE_LOW;
            t_fwd   <= '0;
            t_rev   <= '0;
        end else begin
            fault_q <= fault_q | fault;
            mode_q  <= drv_mode_t'(mode_hi);
            t_fwd   <= fault_q ? 3'b000 : fwd_c;
            t_rev   <= fault_q ? 3'b000 : rev_c;
        end
    end

    assign hs_mode = (mode_q == MODE_HIGH);

    for (genvar k = 0; k < N_LEGS; k++) begin : g_leg
        dmi_phase_win #(
            .ANG_W  (ANG_W),
            .OFFSET (leg_offset(k, FULL))
        ) u_win (
            .theta   (theta),
            .blk     (blk_q),
            .mode    (mode_q),
            .cmp     (cmp[k]),
            .req     (req[k]),
            .thy_fwd (fwd_c[k]),
            .thy_rev (rev_c[k])
        );

        dmi_leg_dt #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk  (clk),
            .rst  (rst),
            .kill (fault_q),
            .req  (req[k]),
            .up_q (q_up[k]),
            .dn_q (q_dn[k])
        );
    end

    // R5: the two thyristors of a phase are never fired together
    assert_thy_excl_R5: assert property (@(posedge clk) disable iff (rst)
        (t_fwd & t_rev) == 3'b000);

    // R9: once a fault is latched, all gates go low on the following edge
    assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        fault_q |=> ({q_up, q_dn, t_fwd, t_rev} == 12'd0));

    // R11: the mode flag follows the mode input one cycle later
    assert_mode_flag_R11: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (hs_mode == $past(mode_hi)));

endmodule

// File: tb/dmi_gate_seq_test.sv
module dmi_gate_seq_test;
    localparam int CLK_NS   = 10;
    localparam int DEAD     = 2;
    localparam int HOLD     = DEAD + 3;
    localparam int WD_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] angle = '0;
    logic [11:0] adv_ang = '0;
    logic [11:0] blank_ang = '0;
    logic        mode_hi = 1'b0;
    logic [2:0]  cmp = '0;
    logic        fault = 1'b0;
    logic [2:0]  q_up, q_dn, t_fwd, t_rev, state_idx;
    logic        hs_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    dmi_gate_seq #(.ANG_W(12), .DEAD_CYC(DEAD)) uut (
        .clk(clk), .rst(rst), .angle(angle), .adv_ang(adv_ang),
        .blank_ang(blank_ang), .mode_hi(mode_hi), .cmp(cmp), .fault(fault),
        .q_up(q_up), .q_dn(q_dn), .t_fwd(t_fwd), .t_rev(t_rev),
        .state_idx(state_idx), .hs_mode(hs_mode)
    );

    function automatic int clamp60(input int v);
        return (v > 682) ? 682 : v;
    endfunction

    // Expected gates from R1..R6: {up, dn, fwd, rev, state}
    function automatic logic [14:0] expect_gates(input int a, input int adv,
                                                  input int blk, input bit hi,
                                                  input logic [2:0] c);
        int th, p, b, lo_off;
        logic [2:0] up, dn, fw, rv;
        int offs [3];
        offs[0] = 0; offs[1] = 1365; offs[2] = 2731;
        th = (a + clamp60(adv)) % 4096;
        b  = hi ? clamp60(blk) : 682;
        for (int k = 0; k < 3; k++) begin
            p = (th - offs[k] + 4096) % 4096;
            lo_off = 4096 - b;
            up[k] = (p < 2048 - b) && (hi || c[k]);
            dn[k] = (p >= 2048) && (p < lo_off) && (hi || c[k]);
            fw[k] = (p < 2048);
            rv[k] = !(p < 2048);
        end
        return {up, dn, fw, rv, 3'((th * 6) / 4096)};
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (angle %0d)", req, act, exp, angle);
        end
    endtask

    task automatic check_all(input string tag_tr, input int adv, input int blk,
                             input bit hi);
        logic [14:0] e;
        e = expect_gates(int'(angle), adv, blk, hi, cmp);
        check("R1 state", 32'(state_idx), 32'(e[2:0]));
        check(tag_tr, 32'({q_up, q_dn}), 32'(e[14:9]));
        check("R5 thyristors", 32'({t_fwd, t_rev}), 32'(e[8:3]));
    endtask

    task automatic restart(input int adv, input int blk, input bit hi);
        @(negedge clk);
        rst = 1'b1; adv_ang = 12'(adv); blank_ang = 12'(blk); mode_hi = hi;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic settle_at(input int a);
        angle = 12'(a);
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic sweep(input string tag_tr, input int adv, input int blk,
                         input bit hi, input bit chop);
        restart(adv, blk, hi);
        for (int a = 0; a < 4096; a++) begin
            if (chop) cmp = 3'(a[2:0] ^ a[5:3]);
            settle_at(a);
            check_all(tag_tr, adv, blk, hi);
        end
        cmp = '0;
    endtask

    initial begin : watchdog
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int offs_seen, off_cnt;
        bit both_on;
        // R10: outputs quiet during reset
        repeat (3) @(negedge clk);
        check("R10 reset gates", 32'({q_up, q_dn, t_fwd, t_rev}), 32'd0);
        check("R10 reset state", 32'(state_idx), 32'd0);

        // R11: mode flag one cycle behind the input
        rst = 1'b0;
        mode_hi = 1'b1;
        @(negedge clk);
        check("R11 mode flag high", 32'(hs_mode), 32'd1);
        mode_hi = 1'b0;
        @(negedge clk);
        check("R11 mode flag low", 32'(hs_mode), 32'd0);

        // R2 R3 R1 R5: plain 120-degree drive, then advance with partial blanking
        sweep("R3 hs blank60", 0, 682, 1'b1, 1'b0);
        sweep("R3 R2 hs adv300 blank200", 300, 200, 1'b1, 1'b0);
        // R6: out-of-range setpoints clamp to 682; blank 0 gives full 180 degrees
        sweep("R6 R3 hs adv clamp blank0", 4000, 0, 1'b1, 1'b0);
        // R4: low-speed chopping, blanking input ignored
        sweep("R4 ls chop", 100, 0, 1'b0, 1'b1);

        // R7: setpoint change inside a state has no effect until the next state
        restart(0, 682, 1'b1);
        settle_at(1500);
        check_all("R7 before change", 0, 682, 1'b1);
        blank_ang = 12'd0;
        repeat (HOLD) @(negedge clk);
        check_all("R7 held inside state", 0, 682, 1'b1);
        settle_at(2100);
        check_all("R7 taken at next state", 0, 0, 1'b1);

        // R8: direct upper-to-lower hand-over on phase A
        restart(0, 0, 1'b1);
        settle_at(2047);
        check("R8 upper on before", 32'({q_up[0], q_dn[0]}), 32'b10);
        angle = 12'd2048;
        off_cnt = 0;
        both_on = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (q_up[0] && q_dn[0]) both_on = 1'b1;
            if (!q_up[0] && !q_dn[0]) off_cnt++;
        end
        check("R8 never both on", 32'(both_on), 32'd0);
        offs_seen = (off_cnt >= DEAD && off_cnt <= DEAD + 1) ? 1 : 0;
        check("R8 dead-time gap length", 32'(offs_seen), 32'd1);
        check("R8 lower on after", 32'({q_up[0], q_dn[0]}), 32'b01);

        // R9: fault silences all gates and stays latched
        restart(0, 682, 1'b1);
        settle_at(100);
        check_all("R3 before fault", 0, 682, 1'b1);
        fault = 1'b1;
        @(negedge clk);
        fault = 1'b0;
        @(negedge clk);
        check("R9 gates off after fault", 32'({q_up, q_dn, t_fwd, t_rev}), 32'd0);
        settle_at(2500);
        mode_hi = 1'b0;
        cmp = 3'b111;
        repeat (HOLD) @(negedge clk);
        check("R9 gates stay off", 32'({q_up, q_dn, t_fwd, t_rev}), 32'd0);
        cmp = '0;

        // R10: reset clears the fault and the gates resume
        restart(0, 682, 1'b1);
        settle_at(100);
        check_all("R10 resume after reset", 0, 682, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule